// File: doc/BRIEF.md
# Strobe-Latched Parallel Port

This block is an 8-bit parallel port that software drives through a small register bus. Each pin can be set as an input or an output. Output pins carry the value last written to the port data register. Input pins are read live through the same register. Reading an output pin returns the value being driven, not the level seen on the pin.

A separate strobe input works as a capture trigger. It passes through a two-flop synchronizer and then an edge detector, and the control register selects which edge is active. On that edge the pins are copied into a latch register and a sticky capture flag is set. When the interrupt enable bit is also set, the flag raises an active-high interrupt request.

Software clears the flag in two steps. It first reads the control register while the flag is set, and then reads the latch register. This lets an interrupt handler clear the request just by reading the captured data.

Top module: `strobe_port`

## Requirements
- R1: After reset the control register reads 0x03 (bit 2 is unspecified and not compared), the direction register reads 0x00, pin_oe is 0x00 and irq is low.
- R2: The register offsets are control 2, port data 3, latch 5 and direction 7. A write at offset 7 sets pin_oe. A write at offset 3 sets pin_out. Both registers read back what was written.
- R3: A read at offset 3 returns, for each bit, the driven output value when the direction bit is 1, and pin_in when the direction bit is 0.
- R4: When control bit 4 is 0, the strobe edge picked by control bit 1 (1 = rising, 0 = falling) copies pin_in into the latch (offset 5) and sets control bit 7. The result is visible within 3 clock edges of the strobe change. The other edge changes neither the latch nor the flag.
- R5: irq is high exactly when control bit 7 and control bit 6 are both 1.
- R6: When control bit 4 is 1, strobe edges neither load the latch nor set the flag.
- R7: Control bit 7 is read-only, and writes do not change it. Control bits 6..0 are stored and read back. Bit 0 has no effect on which edge captures.
- R8: The flag clears only when a latch read follows a control read made while the flag was 1. A latch read on its own does not clear it. Any other register access between the two reads also stops the clear.
- R9: If an active edge is detected in the same cycle as the clearing latch read, the flag stays set and the latch takes the new pin value.
- R10: Reads at unused offsets return 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe; its side effects act at the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| pin_in | input | 8 | Pin levels |
| pin_out | output | 8 | Output driver values |
| pin_oe | output | 8 | Per-pin output enable (1 = output) |
| strobe_in | input | 1 | Asynchronous capture strobe |
| irq | output | 1 | Interrupt request, active high |

## Verification
A capture flag stuck high shows on irq and in control bit 7 as soon as the interrupt is enabled. A wrongly armed clear sequence shows on the next latch read, when irq drops when it should not. A faulty synchronizer or edge-select path shows within three clocks of a strobe change, either as a missing flag or as a latch value that does not match the pins. Direction or output-value errors show in the same cycle on pin_oe, pin_out and the port data read.

// File: rtl/strobe_port_pkg.sv
// Package: shared constants for the strobe-latched parallel port.
// Assumes an 8-bit control register whose bit positions are fixed below.
package strobe_port_pkg;
    localparam int OFF_CTRL  = 2;
    localparam int OFF_DATA  = 3;
    localparam int OFF_LATCH = 5;
    localparam int OFF_DIR   = 7;

    localparam int BIT_FLAG  = 7;
    localparam int BIT_IE    = 6;
    localparam int BIT_HS    = 4;
    localparam int BIT_EDGE  = 1;

    // reset value of control bits 6..0
    localparam logic [6:0] CTRL_RESET = 7'b000_0011;
endpackage

// File: rtl/sp_strobe_edge.sv
// Module: synchronizes the asynchronous strobe and flags the selected edge.
// Assumes strobe_in may change at any time; the result comes SYNC_STAGES
// cycles later, as one pulse for each accepted edge.
module sp_strobe_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_in,
    input  logic rise_sel,
    input  logic enable,
    output logic edge_hit
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] stage_q;
    logic               sync_now;
    logic               sync_prev;

    // shift the strobe through the synchronizer plus one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= {stage_q[CHAIN_W-2:0], strobe_in};
    end

    assign sync_now  = stage_q[SYNC_STAGES-1];
    assign sync_prev = stage_q[SYNC_STAGES];

    // compare synchronized level with its history for the selected edge
    always_comb begin
        if (rise_sel) edge_hit = enable & sync_now & ~sync_prev;
        else          edge_hit = enable & ~sync_now & sync_prev;
    end
endmodule

// File: rtl/sp_flag_ctrl.sv
// Module: sticky capture flag with its two-step read-clear sequence.
// Assumes single-cycle read strobes; a capture wins over a clear.
module sp_flag_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic ctrl_rd,
    input  logic latch_rd,
    input  logic other_access,
    output logic flag_q,
    output logic armed_q
);
    // set on capture, clear on an armed latch read
    always_ff @(posedge clk) begin
        if (!rst_n)                    flag_q <= 1'b0;
        else if (capture)              flag_q <= 1'b1;
        else if (latch_rd && armed_q)  flag_q <= 1'b0;
    end

    // arm when control is read with the flag up; any other access disarms
    always_ff @(posedge clk) begin
        if (!rst_n)                        armed_q <= 1'b0;
        else if (ctrl_rd)                  armed_q <= flag_q;
        else if (latch_rd || other_access) armed_q <= 1'b0;
    end
endmodule

// File: rtl/sp_port_regs.sv
// Module: direction, output, latch and stored control bits.
// Assumes write enables are already decoded; the latch loads on capture.
module sp_port_regs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_data,
    input  logic              wr_dir,
    input  logic [DATA_W-1:0] wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] pin_in,
    output logic [DATA_W-2:0] ctrl_q,
    output logic [DATA_W-1:0] out_q,
    output logic [DATA_W-1:0] dir_q,
    output logic [DATA_W-1:0] latch_q
);
    import strobe_port_pkg::*;

    // writable control bits (everything below the flag)
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= CTRL_RESET;
        else if (wr_ctrl) ctrl_q <= wdata[DATA_W-2:0];
    end

    // output driver values
    always_ff @(posedge clk) begin
        if (!rst_n)       out_q <= '0;
        else if (wr_data) out_q <= wdata;
    end

    // per-pin direction, all inputs after reset
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= '0;
        else if (wr_dir) dir_q <= wdata;
    end

    // captured pin snapshot
    always_ff @(posedge clk) begin
        if (!rst_n)       latch_q <= '0;
        else if (capture) latch_q <= pin_in;
    end
endmodule

// File: rtl/strobe_port.sv
// Module: top of the strobe-latched parallel port. It decodes the register
// bus, muxes read data and gates the interrupt.
// Assumes bus_rd and bus_wr are one-cycle pulses; read data is combinational.
module strobe_port #(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] pin_in,
    output logic [DATA_W-1:0] pin_out,
    output logic [DATA_W-1:0] pin_oe,
    input  logic              strobe_in,
    output logic              irq
);
    import strobe_port_pkg::*;

    logic              hit_ctrl, hit_data, hit_latch, hit_dir;
    logic              ctrl_rd, latch_rd, other_access;
    logic              edge_hit, flag_q, armed_q;
    logic [DATA_W-2:0] ctrl_q;
    logic [DATA_W-1:0] out_q, dir_q, latch_q, port_view;

    // address decode
    assign hit_ctrl  = (bus_addr == ADDR_W'(OFF_CTRL));
    assign hit_data  = (bus_addr == ADDR_W'(OFF_DATA));
    assign hit_latch = (bus_addr == ADDR_W'(OFF_LATCH));
    assign hit_dir   = (bus_addr == ADDR_W'(OFF_DIR));

    assign ctrl_rd      = bus_rd & hit_ctrl;
    assign latch_rd     = bus_rd & hit_latch;
    assign other_access = (bus_rd | bus_wr) & ~ctrl_rd & ~latch_rd;

    sp_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_in(strobe_in),
        .rise_sel (ctrl_q[BIT_EDGE]),
        .enable   (~ctrl_q[BIT_HS]),
        .edge_hit (edge_hit)
    );

    sp_flag_ctrl u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (edge_hit),
        .ctrl_rd     (ctrl_rd),
        .latch_rd    (latch_rd),
        .other_access(other_access),
        .flag_q      (flag_q),
        .armed_q     (armed_q)
    );

    sp_port_regs #(.DATA_W(DATA_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_ctrl(bus_wr & hit_ctrl),
        .wr_data(bus_wr & hit_data),
        .wr_dir (bus_wr & hit_dir),
        .wdata  (bus_wdata),
        .capture(edge_hit),
        .pin_in (pin_in),
        .ctrl_q (ctrl_q),
        .out_q  (out_q),
        .dir_q  (dir_q),
        .latch_q(latch_q)
    );

    // per-pin read view: driven value for outputs, pin level for inputs
    for (genvar i = 0; i < DATA_W; i++) begin : g_view
        assign port_view[i] = dir_q[i] ? out_q[i] : pin_in[i];
    end

    // read data mux
    always_comb begin
        if (hit_ctrl)       bus_rdata = {flag_q, ctrl_q};
        else if (hit_data)  bus_rdata = port_view;
        else if (hit_latch) bus_rdata = latch_q;
        else if (hit_dir)   bus_rdata = dir_q;
        else                bus_rdata = '0;
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
    assign irq     = flag_q & ctrl_q[BIT_IE];
endmodule

// File: rtl/sp_checker.sv
// Checker: temporal properties of the strobe port, bound to the top.
module sp_checker #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] pin_in,
    input logic [DATA_W-1:0] pin_oe,
    input logic              irq,
    input logic              edge_hit,
    input logic              flag_q,
    input logic              armed_q,
    input logic [DATA_W-1:0] latch_q
);
    import strobe_port_pkg::*;

    a_r1_reset_inputs: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pin_oe == '0 && !irq));

    a_r4_flag_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> flag_q);

    a_r4_latch_loads: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> (latch_q == $past(pin_in)));

    a_r4_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_hit |=> $stable(latch_q));

    a_r5_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_q |-> !irq);

    a_r8_clear_sequence: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(bus_rd && bus_addr == ADDR_W'(OFF_LATCH) && armed_q));

    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit && bus_rd && bus_addr == ADDR_W'(OFF_LATCH)) |=> flag_q);
endmodule

bind strobe_port sp_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_rd  (bus_rd),
    .bus_addr(bus_addr),
    .pin_in  (pin_in),
    .pin_oe  (pin_oe),
    .irq     (irq),
    .edge_hit(edge_hit),
    .flag_q  (flag_q),
    .armed_q (armed_q),
    .latch_q (latch_q)
);

// File: tb/tb_strobe_port.sv
// Directed bench for strobe_port: one task for each scenario.
module tb_strobe_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_oe;
    logic       strobe_in = 1'b0, irq;
    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    strobe_port dut (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_rd = 1; bus_addr = a;
        #2 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic strobe_to(input logic v);
        strobe_in = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk("R1 pin_oe", pin_oe, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);
        rd(2, d); chk("R1 ctrl", d & 8'hFB, 8'h03);
        rd(7, d); chk("R1 dir", d, 8'h00);
    endtask

    task automatic t_port_io;
        logic [7:0] d;
        wr(7, 8'h0F); wr(3, 8'hA5); pin_in = 8'h3C;
        chk("R2 pin_oe", pin_oe, 8'h0F);
        chk("R2 pin_out", pin_out, 8'hA5);
        rd(7, d); chk("R2 dir readback", d, 8'h0F);
        rd(3, d); chk("R3 mixed view", d, 8'h35);
        wr(7, 8'hF0); wr(3, 8'h5A); pin_in = 8'h96;
        rd(3, d); chk("R3 mixed view 2", d, 8'h56);
    endtask

    task automatic t_capture;
        logic [7:0] d;
        wr(2, 8'h03); pin_in = 8'h9C; strobe_to(1);
        rd(5, d); chk("R4 rising capture", d, 8'h9C);
        rd(2, d); chk("R4 flag set", d, 8'h83);
        rd(5, d); chk("R8 sequence latch", d, 8'h9C);
        rd(2, d); chk("R8 flag cleared", d, 8'h03);
        pin_in = 8'h11; strobe_to(0);
        rd(5, d); chk("R4 falling ignored", d, 8'h9C);
        wr(2, 8'h41); strobe_to(1);
        chk("R7 rising ignored in falling mode", {7'b0, irq}, 8'h00);
        pin_in = 8'h7E; strobe_to(0);
        chk("R5 irq on flag and enable", {7'b0, irq}, 8'h01);
        rd(5, d); chk("R7 falling capture with bit0 set", d, 8'h7E);
    endtask

    task automatic t_irq_and_ro;
        logic [7:0] d;
        wr(2, 8'h01);
        chk("R5 irq masked", {7'b0, irq}, 8'h00);
        rd(2, d); chk("R7 flag survives write", d, 8'h81);
        wr(2, 8'h41);
        chk("R5 irq re-enabled", {7'b0, irq}, 8'h01);
    endtask

    task automatic t_clear_order;
        logic [7:0] d;
        rd(5, d);
        chk("R8 latch read alone", {7'b0, irq}, 8'h01);
        rd(2, d); rd(7, d); rd(5, d);
        chk("R8 interrupted sequence", {7'b0, irq}, 8'h01);
        rd(2, d); rd(5, d);
        chk("R8 proper sequence clears", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_handshake_mode;
        logic [7:0] d;
        wr(2, 8'h13); pin_in = 8'h55; strobe_to(1);
        rd(5, d); chk("R6 no capture", d, 8'h7E);
        rd(2, d); chk("R6 no flag", d, 8'h13);
        strobe_to(0);
        wr(2, 8'hFF);
        rd(2, d); chk("R7 flag not writable", d, 8'h7F);
    endtask

    task automatic t_same_cycle;
        logic [7:0] d;
        wr(2, 8'h43); pin_in = 8'h21; strobe_to(1); strobe_to(0);
        chk("R9 precondition flag", {7'b0, irq}, 8'h01);
        pin_in = 8'hD4; strobe_in = 1; bus_rd = 1; bus_addr = 2;
        @(posedge clk); @(negedge clk); bus_rd = 0;
        @(posedge clk); @(negedge clk); bus_rd = 1; bus_addr = 5;
        @(posedge clk); @(negedge clk); bus_rd = 0;
        chk("R9 edge wins over clear", {7'b0, irq}, 8'h01);
        rd(5, d); chk("R9 latch new value", d, 8'hD4);
        rd(2, d); rd(5, d);
        chk("R9 later clear", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_unmapped;
        logic [7:0] d;
        wr(0, 8'hFF); wr(4, 8'hFF);
        rd(0, d); chk("R10 offset 0 reads zero", d, 8'h00);
        rd(4, d); chk("R10 offset 4 reads zero", d, 8'h00);
        rd(7, d); chk("R10 dir untouched", d, 8'hF0);
        chk("R10 pin_out untouched", pin_out, 8'h5A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_port_io();
        t_capture();
        t_irq_and_ro();
        t_clear_order();
        t_handshake_mode();
        t_same_cycle();
        t_unmapped();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule